// File: doc/BRIEF.md
# SPI Serial Memory Read Front End

This block is the slave side of an SPI link that gives a host read access to a byte-wide memory. It runs on the system clock. It synchronises the SPI pins and detects the serial clock edges in that clock domain. After chip select goes low, it collects an 8-bit command. A read command is followed by a 16-bit start address. From then on the block fetches bytes from an external synchronous memory port and sends them out. The address steps up after every byte. At the top address it wraps to zero. The stream has no length limit and stops only when chip select rises.

A second command returns the status byte presented on `status_in`. Any other command is discarded until chip select rises again. The serial output enable is asserted only while data or status bits are being sent. A pad can use it directly to leave the line floating at all other times.

The link uses SPI mode 0. The host samples on the rising serial clock edge, and the block changes its output after the falling edge. Each serial clock phase must last at least four system clock cycles.

Top module: `spi_rd_frontend`

## Requirements
- R1: While chip select is high, the command and address bit counters are held at zero. A partly sent command is therefore lost. The next transfer starts with a fresh 8-bit command, sampled MSB first on rising serial clock edges.
- R2: Command 0x03 selects a read and must be followed by a 16-bit address, MSB first. Until the last address bit has been sampled, the block issues no memory read and keeps its output enable low.
- R3: After the address, the byte stored at that address is sent MSB first. Its first bit appears after the falling serial clock edge that follows the last address bit, and each later bit appears after the next falling edge.
- R4: After each complete byte on the output, the address advances by one. Continued clocking therefore returns bytes from consecutive addresses.
- R5: Advancing from address 0xFFFF gives 0x0000, and the stream continues without interruption.
- R6: Command 0x05 sends the `status_in` byte right after the command, MSB first. `status_in` is sampled again at each byte boundary while chip select stays low. No memory read is issued.
- R7: Any command other than 0x03 and 0x05 is ignored until chip select rises. The output enable stays low, no memory read occurs, and the next transfer works normally.
- R8: The output enable goes high only on a falling serial clock edge inside a read or status transfer. It returns low within three system clocks after chip select rises, at any point in a transfer.
- R9: While chip select is low, the serial output changes only in response to a falling serial clock edge. It is stable while the serial clock is high.
- R10: Every memory read is a single-cycle `mem_rd` pulse, with `mem_addr` valid in the same cycle. `mem_rdata` is expected one cycle later. A transfer of N bytes issues N+1 reads: the start byte plus one prefetch after each byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the host, idle low |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_oe | output | 1 | High while `spi_miso` carries data; low means the line floats |
| status_in | input | 8 | Status byte returned by command 0x05 |
| mem_addr | output | 16 | Memory read address |
| mem_rd | output | 1 | One-cycle memory read strobe |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_rd` |

## Verification
Each pin change takes two synchroniser edges plus one register edge before it has an effect. The output bit and output enable therefore settle three system clocks after a falling serial clock edge, and `mem_rd` fires three clocks after the rising edge that completes a byte. The bench holds each serial clock phase for five system clocks and samples the output at the end of the low phase, just before it raises the clock. It samples again at the end of the high phase to confirm the bit held steady. After raising chip select it waits six clocks before checking that the output enable is low. It checks memory read counts only after a whole byte phase has passed.

// File: rtl/spi_rd_pkg.sv
// Shared definitions for the SPI read front end: command codes and
// controller states. Assumes 8-bit commands.
package spi_rd_pkg;
    localparam int unsigned OPC_W = 8;
    localparam logic [OPC_W-1:0] OPC_READ   = 8'h03;
    localparam logic [OPC_W-1:0] OPC_STATUS = 8'h05;

    typedef enum logic [2:0] {
        ST_CMD,
        ST_ADDR,
        ST_DATA,
        ST_STAT,
        ST_SKIP
    } rd_state_t;
endpackage

// File: rtl/spi_pin_sync.sv
// Brings the asynchronous SPI pins into the clk domain through STAGES
// flip-flops each, and produces single-cycle rising/falling edge pulses
// of the serial clock. Assumes STAGES >= 2 and a serial clock phase of
// at least STAGES+2 system clocks.
module spi_pin_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic mosi,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_act,
    output logic mosi_s
);
    logic [STAGES-1:0] sck_q;
    logic [STAGES-1:0] cs_q;
    logic [STAGES-1:0] mo_q;
    logic              sck_d;

    // Synchroniser chains; chip select resets to inactive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q <= '0;
            cs_q  <= '1;
            mo_q  <= '0;
            sck_d <= 1'b0;
        end else begin
            sck_q <= {sck_q[STAGES-2:0], sck};
            cs_q  <= {cs_q[STAGES-2:0], cs_n};
            mo_q  <= {mo_q[STAGES-2:0], mosi};
            sck_d <= sck_q[STAGES-1];
        end
    end

    // Edge pulses and synchronised levels.
    assign sck_rise = sck_q[STAGES-1] & ~sck_d;
    assign sck_fall = ~sck_q[STAGES-1] & sck_d;
    assign cs_act   = ~cs_q[STAGES-1];
    assign mosi_s   = mo_q[STAGES-1];
endmodule

// File: rtl/spi_rd_ctrl.sv
// Command decoder, address shifter and output serialiser. Inputs are the
// synchronised edge pulses. Assumes the memory returns data one cycle
// after mem_rd and that at least three clocks separate edge pulses.
module spi_rd_ctrl
    import spi_rd_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              cs_act,
    input  logic              mosi_s,
    input  logic [DATA_W-1:0] status_in,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              miso,
    output logic              miso_oe
);
    localparam int unsigned CNT_W = $clog2(ADDR_W + 1);
    localparam int unsigned TX_W  = $clog2(DATA_W);

    rd_state_t         st;
    logic [CNT_W-1:0]  in_cnt;
    logic [ADDR_W-1:0] in_sh;
    logic [ADDR_W-1:0] in_nxt;
    logic [TX_W-1:0]   tx_idx;
    logic [DATA_W-1:0] cur_byte;
    logic              rd_q;

    // Shift register value after accepting the current input bit.
    always_comb in_nxt = {in_sh[ADDR_W-2:0], mosi_s};

    // Transfer state machine, input shifting and output serialising.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_CMD;
            in_cnt   <= '0;
            in_sh    <= '0;
            tx_idx   <= '0;
            cur_byte <= '0;
            rd_q     <= 1'b0;
            mem_addr <= '0;
            mem_rd   <= 1'b0;
            miso     <= 1'b0;
            miso_oe  <= 1'b0;
        end else begin
            mem_rd <= 1'b0;
            rd_q   <= mem_rd;
            if (rd_q) cur_byte <= mem_rdata;
            if (!cs_act) begin
                st      <= ST_CMD;
                in_cnt  <= '0;
                tx_idx  <= '0;
                miso    <= 1'b0;
                miso_oe <= 1'b0;
            end else begin
                case (st)
                    ST_CMD: if (sck_rise) begin
                        in_sh  <= in_nxt;
                        in_cnt <= in_cnt + 1'b1;
                        if (in_cnt == CNT_W'(OPC_W - 1)) begin
                            in_cnt <= '0;
                            if (in_nxt[OPC_W-1:0] == OPC_READ) begin
                                st <= ST_ADDR;
                            end else if (in_nxt[OPC_W-1:0] == OPC_STATUS) begin
                                st       <= ST_STAT;
                                cur_byte <= status_in;
                            end else begin
                                st <= ST_SKIP;
                            end
                        end
                    end
                    ST_ADDR: if (sck_rise) begin
                        in_sh  <= in_nxt;
                        in_cnt <= in_cnt + 1'b1;
                        if (in_cnt == CNT_W'(ADDR_W - 1)) begin
                            in_cnt   <= '0;
                            mem_addr <= in_nxt;
                            mem_rd   <= 1'b1;
                            st       <= ST_DATA;
                        end
                    end
                    ST_DATA, ST_STAT: if (sck_fall) begin
                        miso_oe  <= 1'b1;
                        miso     <= cur_byte[DATA_W-1];
                        cur_byte <= {cur_byte[DATA_W-2:0], 1'b0};
                        tx_idx   <= tx_idx + 1'b1;
                        if (tx_idx == TX_W'(DATA_W - 1)) begin
                            tx_idx <= '0;
                            if (st == ST_DATA) begin
                                mem_addr <= mem_addr + 1'b1;
                                mem_rd   <= 1'b1;
                            end else begin
                                cur_byte <= status_in;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/spi_rd_frontend.sv
// Top of the SPI read front end: pin synchroniser plus controller.
// Assumes SPI mode 0 and a serial clock no faster than clk/8.
module spi_rd_frontend #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sck,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    input  logic [DATA_W-1:0] status_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    input  logic [DATA_W-1:0] mem_rdata
);
    logic sck_rise;
    logic sck_fall;
    logic cs_act;
    logic mosi_s;

    // Pin synchronisation and edge detection.
    spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .sck(spi_sck), .cs_n(spi_cs_n),
        .mosi(spi_mosi), .sck_rise(sck_rise), .sck_fall(sck_fall),
        .cs_act(cs_act), .mosi_s(mosi_s)
    );

    // Command handling and data serialising.
    spi_rd_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .sck_rise(sck_rise), .sck_fall(sck_fall),
        .cs_act(cs_act), .mosi_s(mosi_s), .status_in(status_in),
        .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .miso(spi_miso), .miso_oe(spi_miso_oe)
    );
endmodule

// File: rtl/spi_rd_chk.sv
// Protocol checker bound to spi_rd_frontend. It watches the synchronised
// chip select and edge pulses and relates them to the output pins and
// the memory port.
module spi_rd_chk #(
    parameter int unsigned ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_act,
    input logic              sck_fall,
    input logic              spi_miso,
    input logic              spi_miso_oe,
    input logic              mem_rd,
    input logic [ADDR_W-1:0] mem_addr
);
    logic              have_prev;
    logic [ADDR_W-1:0] prev_addr;

    // Remember the last read address inside the current transfer.
    always_ff @(posedge clk) begin
        if (!rst_n || !cs_act) begin
            have_prev <= 1'b0;
            prev_addr <= '0;
        end else if (mem_rd) begin
            have_prev <= 1'b1;
            prev_addr <= mem_addr;
        end
    end

    p_oe_off_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> !spi_miso_oe);
    p_oe_on_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_miso_oe) |-> $past(sck_fall));
    p_miso_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_act && !sck_fall) |=> $stable(spi_miso));
    p_rd_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);
    p_rd_in_xfer_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> $past(cs_act));
    // Covers R5 as well: the sum wraps at the address width.
    p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && have_prev) |-> (mem_addr == ADDR_W'(prev_addr + 1'b1)));
endmodule

bind spi_rd_frontend spi_rd_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .sck_fall(sck_fall),
    .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe), .mem_rd(mem_rd),
    .mem_addr(mem_addr)
);

// File: tb/tb_spi_rd_frontend.sv
// Directed bench: acts as the SPI host, models a one-cycle synchronous
// memory whose contents are a function of the address.
module tb_spi_rd_frontend;
    localparam int HALF = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        spi_sck = 1'b0;
    logic        spi_cs_n = 1'b1;
    logic        spi_mosi = 1'b0;
    logic        spi_miso;
    logic        spi_miso_oe;
    logic [7:0]  status_in = 8'h00;
    logic [15:0] mem_addr;
    logic        mem_rd;
    logic [7:0]  mem_rdata = 8'h00;

    int n_chk = 0;
    int n_fail = 0;
    int rd_cnt = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    spi_rd_frontend dut (
        .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
        .status_in(status_in), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_rdata(mem_rdata)
    );

    function automatic logic [7:0] mem_pat(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
    endfunction

    // Memory model with one cycle of read latency; counts reads.
    always @(posedge clk) begin
        if (mem_rd) begin
            mem_rdata <= mem_pat(mem_addr);
            rd_cnt    <= rd_cnt + 1;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One SCK period: drive data, sample at the end of the low phase and of the high phase.
    task automatic spi_bit(input logic b, output logic r, output logic oe, output logic r_hi);
        @(negedge clk) spi_mosi = b;
        repeat (HALF) @(negedge clk);
        r  = spi_miso;
        oe = spi_miso_oe;
        spi_sck = 1'b1;
        repeat (HALF) @(negedge clk);
        r_hi = spi_miso;
        spi_sck = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] v, output logic any_oe);
        any_oe = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            logic r, oe, rh;
            spi_bit(v[i], r, oe, rh);
            any_oe |= oe;
        end
    endtask

    task automatic recv_byte(output logic [7:0] v, output logic all_oe, output int unstable);
        all_oe = 1'b1;
        unstable = 0;
        for (int i = 7; i >= 0; i--) begin
            logic r, oe, rh;
            spi_bit(1'b0, r, oe, rh);
            v[i] = r;
            all_oe &= oe;
            if (rh !== r) unstable++;
        end
    endtask

    task automatic cs_low();
        @(negedge clk) spi_cs_n = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic cs_high();
        @(negedge clk) spi_cs_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic t_reset();
        check(spi_miso_oe === 1'b0, "R8", "oe after reset", 32'(spi_miso_oe), 0);
        check(mem_rd === 1'b0 && rd_cnt == 0, "R10", "no read after reset", rd_cnt, 0);
    endtask

    // Read n bytes from addr and check data, enable, stability and read count.
    task automatic t_read(input logic [15:0] addr, input int n, input string req);
        logic oe_hdr, oe_tmp, all_oe;
        logic [7:0] got;
        int base, uns, uns_tot;
        base = rd_cnt;
        uns_tot = 0;
        cs_low();
        send_byte(8'h03, oe_hdr);
        send_byte(addr[15:8], oe_tmp);
        oe_hdr |= oe_tmp;
        check(rd_cnt == base, "R2", "no read before address done", rd_cnt - base, 0);
        send_byte(addr[7:0], oe_tmp);
        oe_hdr |= oe_tmp;
        check(oe_hdr === 1'b0, "R2", "oe low during header", 32'(oe_hdr), 0);
        for (int k = 0; k < n; k++) begin
            logic [15:0] a;
            a = addr + 16'(k);
            recv_byte(got, all_oe, uns);
            uns_tot += uns;
            check(got === mem_pat(a), req, "read byte", got, mem_pat(a));
            check(all_oe === 1'b1, "R8", "oe during data", 32'(all_oe), 1);
        end
        check(uns_tot == 0, "R9", "miso stable in high phase", uns_tot, 0);
        cs_high();
        check(spi_miso_oe === 1'b0, "R8", "oe after cs high", 32'(spi_miso_oe), 0);
        check(rd_cnt - base == n + 1, "R10", "read pulse count", rd_cnt - base, n + 1);
    endtask

    task automatic t_status();
        logic oe_hdr, all_oe;
        logic [7:0] got;
        int base, uns;
        base = rd_cnt;
        status_in = 8'hC6;
        cs_low();
        send_byte(8'h05, oe_hdr);
        status_in = 8'h3B;
        recv_byte(got, all_oe, uns);
        check(got === 8'hC6, "R6", "status byte", got, 8'hC6);
        check(all_oe === 1'b1, "R8", "oe during status", 32'(all_oe), 1);
        recv_byte(got, all_oe, uns);
        check(got === 8'h3B, "R6", "status resampled", got, 8'h3B);
        cs_high();
        check(rd_cnt == base, "R6", "no memory read for status", rd_cnt - base, 0);
    endtask

    task automatic t_bad_op();
        logic any_oe, oe_tmp;
        int base;
        base = rd_cnt;
        cs_low();
        send_byte(8'h9F, any_oe);
        send_byte(8'h00, oe_tmp);
        any_oe |= oe_tmp;
        send_byte(8'h03, oe_tmp);
        any_oe |= oe_tmp;
        check(any_oe === 1'b0, "R7", "oe stays low", 32'(any_oe), 0);
        cs_high();
        check(rd_cnt == base, "R7", "no read on unknown command", rd_cnt - base, 0);
    endtask

    task automatic t_partial();
        cs_low();
        for (int i = 0; i < 4; i++) begin
            logic r, oe, rh;
            spi_bit(i < 2 ? 1'b1 : 1'b0, r, oe, rh);
        end
        cs_high();
        t_read(16'h1234, 1, "R1");
    endtask

    task automatic t_abort();
        logic oe_hdr;
        cs_low();
        send_byte(8'h03, oe_hdr);
        send_byte(8'h01, oe_hdr);
        send_byte(8'h00, oe_hdr);
        for (int i = 0; i < 3; i++) begin
            logic r, oe, rh;
            spi_bit(1'b0, r, oe, rh);
        end
        check(spi_miso_oe === 1'b1, "R8", "oe mid byte", 32'(spi_miso_oe), 1);
        @(negedge clk) spi_cs_n = 1'b1;
        repeat (3) @(negedge clk);
        check(spi_miso_oe === 1'b0, "R8", "oe off after abort", 32'(spi_miso_oe), 0);
        repeat (4) @(negedge clk);
        t_read(16'h0200, 1, "R3");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_read(16'h0010, 3, "R3");
        t_read(16'h7FF0, 4, "R4");
        t_read(16'hFFFE, 4, "R5");
        t_status();
        t_bad_op();
        t_read(16'h00A0, 2, "R7");
        t_partial();
        t_abort();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule